// File: doc/BRIEF.md
# Standby-Aware Clock Enable Controller

This block produces clock-enable strobes for two domains, a processor core and a system bus, from a single master clock. Nothing is gated in logic. Every consumer stays on the master clock and advances only in cycles where its enable is high, so the whole design remains one synchronous clock domain. The core enable can be slowed by a power-of-two ratio from 1/1 to 1/8, which lets software trade speed for power.

The core can request one of two standby states, a light halt or a deep sleep. Either state removes the core enable. In halt, the bus enable keeps running or stops according to a programmable bit, so bus masters such as a display fetch or a DMA engine can keep working while the core rests. In sleep, the bus enable always stops. An interrupt on the wake input returns the block to run. A small write port loads the divide ratio and the bus-in-halt bit. A status output reports the current mode.

Top module: `clk_ce_ctrl`

## Requirements
- R1: After synchronous reset the mode is run (status 0), the divide ratio is 0 and the bus-in-halt bit is 1. Both enables are then high in every cycle.
- R2: A write with wr_sel=0 loads the 2-bit ratio from wr_data. Ratio n gives one core enable pulse every 2^n master cycles in run mode: 0→every cycle, 1→every 2nd, 2→every 4th, 3→every 8th.
- R3: A ratio write restarts the divider. The first core enable after the write comes exactly 2^n cycles after the write edge.
- R4: A halt request in run mode moves the block to halt (status 1) at the next edge. The core enable is low from that cycle on.
- R5: A sleep request in run mode moves the block to sleep (status 2) at the next edge. Both enables are then low, whatever the bus-in-halt bit holds.
- R6: When halt and sleep are requested in the same cycle, sleep wins.
- R7: A write with wr_sel=1 loads the bus-in-halt bit from wr_data[0]. In halt, the bus enable is high when the bit is 1 and low when it is 0.
- R8: A wake interrupt in halt or sleep returns the block to run at the next edge. The bus enable is high from that cycle. The divider restarts, so the first core enable comes 2^n cycles after the wake edge.
- R9: A wake interrupt while already in run has no effect. The divider phase is unchanged.
- R10: In run mode the bus enable is high in every cycle, regardless of the bus-in-halt bit.
- R11: In halt or sleep, halt and sleep requests are ignored. The status stays as it was until a wake interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_req | input | 1 | Core request to enter halt |
| sleep_req | input | 1 | Core request to enter sleep |
| wake_irq | input | 1 | Interrupt that ends standby |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 divide ratio, 1 bus-in-halt bit |
| wr_data | input | 2 | Write data |
| core_ce | output | 1 | Core clock-enable strobe |
| bus_ce | output | 1 | Bus clock-enable |
| mode_o | output | 2 | Current mode: 0 run, 1 halt, 2 sleep |

## Verification
The hardest behaviour to see from the ports is the divider phase. A restart after a wake or a ratio write must be told apart from a counter that merely keeps running, and a wake in run must leave the phase untouched. The bench reaches this by programming the 1/4 ratio and then placing a wake interrupt in mid-period, both from standby and from run. It then counts the exact cycle of the next core pulse: a wrongly restarted or a wrongly free-running divider moves that pulse by two cycles.

// File: rtl/clk_ce_pkg.sv
package clk_ce_pkg;

    // Width of the ratio selector; the largest slowdown is 2^(2^DIV_W - 1)
    localparam int DIV_W = 2;
    localparam int CNT_W = (2 ** DIV_W) - 1;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_HALT  = 2'd1,
        MODE_SLEEP = 2'd2
    } mode_e;

    // Write-port target codes
    localparam logic SEL_RATIO = 1'b0;
    localparam logic SEL_BUSEN = 1'b1;

    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic             bus_in_halt;
    } cfg_t;

    // Terminal count of the divider for a given ratio
    function automatic logic [CNT_W-1:0] term_count(input logic [DIV_W-1:0] r);
        logic [CNT_W:0] one_hot;
        one_hot = '0;
        one_hot[r] = 1'b1;
        return CNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/clk_ce_cfg.sv
module clk_ce_cfg
    import clk_ce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic             ratio_wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.ratio       <= '0;
            cfg.bus_in_halt <= 1'b1;
        end else if (wr_en) begin
            if (wr_sel == SEL_RATIO)
                cfg.ratio <= wr_data;
            else
                cfg.bus_in_halt <= wr_data[0];
        end
    end

    assign ratio_wr = wr_en && (wr_sel == SEL_RATIO);

    // R7
    busbit_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_BUSEN) |=> (cfg.bus_in_halt == $past(wr_data[0])));

    // R2
    ratio_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_RATIO) |=> (cfg.ratio == $past(wr_data)));

endmodule

// File: rtl/clk_ce_mode.sv
module clk_ce_mode
    import clk_ce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  halt_req,
    input  logic  sleep_req,
    input  logic  wake_irq,
    output mode_e mode,
    output logic  resume
);

    mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_RUN: begin
                if (sleep_req)     mode_nx = MODE_SLEEP;
                else if (halt_req) mode_nx = MODE_HALT;
            end
            MODE_HALT, MODE_SLEEP: begin
                if (wake_irq)      mode_nx = MODE_RUN;
            end
            default:               mode_nx = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_RUN;
        else     mode <= mode_nx;
    end

    assign resume = (mode != MODE_RUN) && wake_irq;

    // R5 R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && sleep_req) |=> (mode == MODE_SLEEP));

    // R4
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && halt_req && !sleep_req) |=> (mode == MODE_HALT));

    // R8
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_RUN && wake_irq) |=> (mode == MODE_RUN));

    // R11
    standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_RUN && !wake_irq) |=> $stable(mode));

    // R9
    run_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && !halt_req && !sleep_req) |=> (mode == MODE_RUN));

endmodule

// File: rtl/clk_ce_div.sv
module clk_ce_div
    import clk_ce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = term_count(ratio);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
    end

    assign tick = run && (cnt == limit);

    // R3 R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R2
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0 && !restart) |=> !tick);

    // R11
    frozen_in_standby_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt));

endmodule

// File: rtl/clk_ce_ctrl.sv
module clk_ce_ctrl
    import clk_ce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_req,
    input  logic             sleep_req,
    input  logic             wake_irq,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    output logic             core_ce,
    output logic             bus_ce,
    output logic [1:0]       mode_o
);

    cfg_t  cfg;
    logic  ratio_wr;
    mode_e mode;
    logic  resume;
    logic  in_run;

    clk_ce_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .ratio_wr (ratio_wr)
    );

    clk_ce_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .halt_req  (halt_req),
        .sleep_req (sleep_req),
        .wake_irq  (wake_irq),
        .mode      (mode),
        .resume    (resume)
    );

    assign in_run = (mode == MODE_RUN);

    clk_ce_div u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (in_run),
        .restart (ratio_wr || resume),
        .ratio   (cfg.ratio),
        .tick    (core_ce)
    );

    always_comb begin
        unique case (mode)
            MODE_RUN:  bus_ce = 1'b1;
            MODE_HALT: bus_ce = cfg.bus_in_halt;
            default:   bus_ce = 1'b0;
        endcase
    end

    assign mode_o = mode;

    // R5
    sleep_bus_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> (!bus_ce && !core_ce));

    // R4
    halt_core_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1) |-> !core_ce);

    // R8
    wake_bus_on_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd0 && wake_irq) |=> bus_ce);

endmodule

// File: tb/clk_ce_ctrl_test.sv
module clk_ce_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       halt_req, sleep_req, wake_irq;
    logic       wr_en, wr_sel;
    logic [1:0] wr_data;
    logic       core_ce, bus_ce;
    logic [1:0] mode_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clk_ce_ctrl uut (
        .clk(clk), .rst(rst),
        .halt_req(halt_req), .sleep_req(sleep_req), .wake_irq(wake_irq),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .core_ce(core_ce), .bus_ce(bus_ce), .mode_o(mode_o)
    );

    // Vector: halt, sleep, wake, wr_en, wr_sel, wr_data[1:0] | mode[1:0], core, bus
    localparam int NV = 15;
    localparam logic [10:0] VEC [NV] = '{
        11'b000_00_00_00_1_1, // R1 run, ratio 0
        11'b100_00_00_01_0_1, // R4 R7 halt, bus bit 1
        11'b000_00_00_01_0_1, // R4 stays halted
        11'b010_00_00_01_0_1, // R11 sleep ignored in halt
        11'b001_00_00_00_1_1, // R8 wake, ratio 0 pulse at once
        11'b000_11_00_00_1_1, // R10 bus bit 0, run keeps bus
        11'b100_00_00_01_0_0, // R7 halt with bit 0
        11'b001_00_00_00_1_1, // R8 wake
        11'b110_00_00_10_0_0, // R6 both requests -> sleep
        11'b000_11_01_10_0_0, // R5 bus bit 1 yet sleep stops bus
        11'b100_00_00_10_0_0, // R11 halt ignored in sleep
        11'b001_00_00_00_1_1, // R8 wake from sleep
        11'b010_00_00_10_0_0, // R5 sleep
        11'b001_00_00_00_1_1, // R8 wake
        11'b001_00_00_00_1_1  // R9 wake in run
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_in();
        halt_req = 0; sleep_req = 0; wake_irq = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 core", core_ce, 1);
        chk("R1 bus", bus_ce, 1);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            {halt_req, sleep_req, wake_irq, wr_en, wr_sel, wr_data} = VEC[i][10:4];
            step();
            chk($sformatf("vec%0d mode", i), mode_o, int'(VEC[i][3:2]));
            chk($sformatf("vec%0d core", i), core_ce, int'(VEC[i][1]));
            chk($sformatf("vec%0d bus", i), bus_ce, int'(VEC[i][0]));
        end
        idle_in();
        step();

        // R2 R3 ratio sweep: pulse when k is a multiple of 2^n
        for (int n = 3; n >= 0; n--) begin
            wr_en = 1; wr_sel = 0; wr_data = 2'(n);
            step();
            idle_in();
            for (int k = 1; k <= 2 * (1 << n); k++) begin
                if (k > 1) step();
                chk($sformatf("R2 R3 ratio%0d k%0d", n, k), core_ce,
                    ((k % (1 << n)) == 0) ? 1 : 0);
            end
        end

        // R8 wake restarts divider (ratio 2)
        wr_en = 1; wr_sel = 0; wr_data = 2'd2;
        step();
        idle_in();
        step();
        halt_req = 1;
        step();
        halt_req = 0;
        chk("R4 halt status", mode_o, 1);
        chk("R7 bus in halt", bus_ce, 1);
        step();
        step();
        wake_irq = 1;
        step();
        wake_irq = 0;
        chk("R8 mode", mode_o, 0);
        chk("R8 bus", bus_ce, 1);
        for (int k = 1; k <= 4; k++) begin
            if (k > 1) step();
            chk($sformatf("R8 core k%0d", k), core_ce, (k == 4) ? 1 : 0);
        end

        // R9 wake in run keeps divider phase (ratio 2)
        wr_en = 1; wr_sel = 0; wr_data = 2'd2;
        step();
        idle_in();
        step();
        wake_irq = 1;
        step();
        wake_irq = 0;
        chk("R9 core k3", core_ce, 0);
        step();
        chk("R9 core k4", core_ce, 1);
        chk("R9 mode", mode_o, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule